// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Logic

This block holds one 32-bit control/status word for each channel of a multi-channel DMA controller and turns the channel events into interrupts. A host reaches the words over a simple register bus, with word-aligned byte addresses and a read result one cycle later. The channel engine that moves the data sits outside the block. It reports start, end, stop, end-of-receive, request-after-stop and bus-error events as one-cycle strobes per channel. Each strobe sets a sticky flag, and the flag stays set until the host writes a 1 to it.

The control part of each word holds run, mask-run, three end-of-receive options, two interrupt enables, a no-descriptor-fetch mode bit, and a pair of commands that set and clear a compare-status flag. Three of the event flags reach the interrupt only when their own enable bit is set. The start and end flags always reach it. The block produces five per-channel interrupt vectors, a global status word at offset 0xF0 that ORs those vectors, and one interrupt line.

Top module: `dma_chan_status`

## Requirements
- R1: After reset, every channel word reads 0x00000008 (stopped flag at bit 3 set, all other bits clear), and both the interrupt line and rdata are 0.
- R2: Writing 1 to bit 0 (bus error), bit 1 (start), bit 2 (end) or bit 9 (end-of-receive) clears that flag. Writing 0 to any of these bits leaves the flag unchanged.
- R3: A write loads bits 31..26 and bit 23 from the write data. Bits 22, 24 and 25 always read 0, and bit 8 is never stored.
- R4: A write with bit 24 set clears the compare flag at bit 10, and a write with bit 25 set sets it. If both bits are set, the flag ends up set.
- R5: A write with run (bit 31) set clears the stopped flag. A write with neither run nor mask-run (bit 22) set forces the stopped flag. A write with mask-run set and run clear leaves the stopped flag unchanged.
- R6: When rd_en is high, rdata on the next cycle holds the addressed word. Channel c sits at byte offset 4*c, bit 8 is ORed in while req_active[c] is high, and an address with no register returns 0. rdata holds its value while rd_en is low.
- R7: An event strobe sets its flag: bus error bit 0, start bit 1, end bit 2, stop bit 3, request-after-stop bit 4, end-of-receive bit 9. A strobe wins over a clear written to the same channel in the same cycle.
- R8: The stop vector bit is stopped AND bit 29. The end-of-receive vector bit is bit 9 AND bit 28. The request-after-stop vector bit is bit 4 AND bit 23. The bus-error flag never reaches an interrupt.
- R9: The start and end vector bits follow their flags with no enable.
- R10: The word at offset 0xF0 is the bitwise OR of the five vectors, and irq is high exactly when that word is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address; bits 1..0 are ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| req_active | input | NUM_CH | Live request-pending input per channel |
| ev_start | input | NUM_CH | Start event strobes |
| ev_end | input | NUM_CH | End event strobes |
| ev_stop | input | NUM_CH | Stop event strobes |
| ev_eor | input | NUM_CH | End-of-receive event strobes |
| ev_ras | input | NUM_CH | Request-after-stop event strobes |
| ev_buserr | input | NUM_CH | Bus error event strobes |
| irq_stop | output | NUM_CH | Gated stop interrupt vector |
| irq_eor | output | NUM_CH | Gated end-of-receive interrupt vector |
| irq_ras | output | NUM_CH | Gated request-after-stop interrupt vector |
| irq_start | output | NUM_CH | Start interrupt vector |
| irq_end | output | NUM_CH | End interrupt vector |
| irq | output | 1 | Combined interrupt line |

## Verification
The write data patterns are chosen to separate the write-one-to-clear bits, the bits loaded directly and the command bits that read back as zero. One all-ones write exercises the case where the set-compare and clear-compare commands are issued together. Run, mask-run and neither are each written on their own, which tells the three stopped-flag outcomes apart. Events are driven with and without their enable bits, which tells gated sources from ungated ones. An event that lands in the same cycle as a clear, or as a run write, shows that the event wins. An end strobe on every channel, followed by a clear of channel 31 alone, checks the top index of the global word and of the vectors. A cycle-level reference model checks all five vectors, the interrupt line and rdata on every clock.

// File: rtl/dmas_pkg.sv
package dmas_pkg;
  localparam int WORD_W = 32;

  // status flag positions
  localparam int F_BUSERR = 0;
  localparam int F_START  = 1;
  localparam int F_END    = 2;
  localparam int F_STOP   = 3;
  localparam int F_RAS    = 4;
  localparam int F_REQ    = 8;
  localparam int F_EOR    = 9;
  localparam int F_CMP    = 10;

  // control positions
  localparam int C_MASKRUN = 22;
  localparam int C_RASEN   = 23;
  localparam int C_CMPCLR  = 24;
  localparam int C_CMPSET  = 25;
  localparam int C_EOREN   = 28;
  localparam int C_STOPEN  = 29;
  localparam int C_RUN     = 31;

  localparam logic [WORD_W-1:0] KEEP_MASK  = 32'h0000_071F;
  localparam logic [WORD_W-1:0] W1C_MASK   = 32'h0000_0207;
  localparam logic [WORD_W-1:0] LOAD_MASK  = 32'hFC80_0000;
  localparam logic [WORD_W-1:0] RESET_WORD = 32'h0000_0008;

  // interrupt source order inside a channel's source bundle
  localparam int S_STOP  = 0;
  localparam int S_EOR   = 1;
  localparam int S_RAS   = 2;
  localparam int S_START = 3;
  localparam int S_END   = 4;
  localparam int NUM_SRC = 5;

  typedef struct packed {
    logic buserr;
    logic start;
    logic done;
    logic stop;
    logic ras;
    logic eor;
  } chan_ev_t;
endpackage

// File: rtl/dmas_chan_reg.sv
module dmas_chan_reg
  import dmas_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wdata,
  input  chan_ev_t          ev,
  output logic [WORD_W-1:0] state_q,
  output logic [NUM_SRC-1:0] src_o
);
  logic [WORD_W-1:0] after_wr;
  logic [WORD_W-1:0] nxt;

  always_comb begin
    after_wr = state_q;
    if (wr_hit) begin
      after_wr = (state_q & KEEP_MASK) & ~(wdata & W1C_MASK);
      after_wr = after_wr | (wdata & LOAD_MASK);
      if (wdata[C_RUN])
        after_wr[F_STOP] = 1'b0;
      else if (!wdata[C_MASKRUN])
        after_wr[F_STOP] = 1'b1;
      if (wdata[C_CMPCLR]) after_wr[F_CMP] = 1'b0;
      if (wdata[C_CMPSET]) after_wr[F_CMP] = 1'b1;
    end
    // engine events win over any clear from the host in the same cycle
    nxt = after_wr;
    if (ev.buserr) nxt[F_BUSERR] = 1'b1;
    if (ev.start)  nxt[F_START]  = 1'b1;
    if (ev.done)   nxt[F_END]    = 1'b1;
    if (ev.stop)   nxt[F_STOP]   = 1'b1;
    if (ev.ras)    nxt[F_RAS]    = 1'b1;
    if (ev.eor)    nxt[F_EOR]    = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= RESET_WORD;
    else     state_q <= nxt;
  end

  always_comb begin
    src_o          = '0;
    src_o[S_STOP]  = state_q[F_STOP] & state_q[C_STOPEN];
    src_o[S_EOR]   = state_q[F_EOR]  & state_q[C_EOREN];
    src_o[S_RAS]   = state_q[F_RAS]  & state_q[C_RASEN];
    src_o[S_START] = state_q[F_START];
    src_o[S_END]   = state_q[F_END];
  end

  AST_RESET_WORD: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> state_q == RESET_WORD); // R1
  AST_W1C_END: assert property (@(posedge clk) disable iff (rst)
    wr_hit && wdata[F_END] && !ev.done |=> !state_q[F_END]); // R2
  AST_CMD_ZERO: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> !state_q[C_CMPSET] && !state_q[C_CMPCLR] && !state_q[C_MASKRUN]); // R3
  AST_CMP_SET: assert property (@(posedge clk) disable iff (rst)
    wr_hit && wdata[C_CMPSET] |=> state_q[F_CMP]); // R4
  AST_CMP_CLR: assert property (@(posedge clk) disable iff (rst)
    wr_hit && wdata[C_CMPCLR] && !wdata[C_CMPSET] |=> !state_q[F_CMP]); // R4
  AST_RUN_CLEARS_STOP: assert property (@(posedge clk) disable iff (rst)
    wr_hit && wdata[C_RUN] && !ev.stop |=> !state_q[F_STOP]); // R5
  AST_IDLE_FORCES_STOP: assert property (@(posedge clk) disable iff (rst)
    wr_hit && !wdata[C_RUN] && !wdata[C_MASKRUN] |=> state_q[F_STOP]); // R5
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    ev.eor |=> state_q[F_EOR]); // R7
  AST_NO_REQ_STORED: assert property (@(posedge clk) disable iff (rst)
    !state_q[F_REQ]); // R3
endmodule

// File: rtl/dmas_irq_comb.sv
module dmas_irq_comb
  import dmas_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic [NUM_SRC-1:0] src [NUM_CH],
  output logic [NUM_CH-1:0]  v_stop,
  output logic [NUM_CH-1:0]  v_eor,
  output logic [NUM_CH-1:0]  v_ras,
  output logic [NUM_CH-1:0]  v_start,
  output logic [NUM_CH-1:0]  v_end,
  output logic [NUM_CH-1:0]  global_o,
  output logic               any_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_tr
    assign v_stop[c]  = src[c][S_STOP];
    assign v_eor[c]   = src[c][S_EOR];
    assign v_ras[c]   = src[c][S_RAS];
    assign v_start[c] = src[c][S_START];
    assign v_end[c]   = src[c][S_END];
  end

  assign global_o = v_stop | v_eor | v_ras | v_start | v_end;
  assign any_o    = |global_o;
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dmas_pkg::*;
#(
  parameter int NUM_CH     = 32,
  parameter int ADDR_W     = 8,
  parameter int GLOBAL_OFS = 'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic [NUM_CH-1:0] req_active,
  input  logic [NUM_CH-1:0] ev_start,
  input  logic [NUM_CH-1:0] ev_end,
  input  logic [NUM_CH-1:0] ev_stop,
  input  logic [NUM_CH-1:0] ev_eor,
  input  logic [NUM_CH-1:0] ev_ras,
  input  logic [NUM_CH-1:0] ev_buserr,
  output logic [NUM_CH-1:0] irq_stop,
  output logic [NUM_CH-1:0] irq_eor,
  output logic [NUM_CH-1:0] irq_ras,
  output logic [NUM_CH-1:0] irq_start,
  output logic [NUM_CH-1:0] irq_end,
  output logic              irq
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [WIDX_W-1:0]  widx;
  logic [WORD_W-1:0]  chan_word [NUM_CH];
  logic [NUM_SRC-1:0] chan_src  [NUM_CH];
  logic [NUM_CH-1:0]  global_vec;
  logic [WORD_W-1:0]  global_word;
  logic [WORD_W-1:0]  rd_mux;

  assign widx = addr[ADDR_W-1:2];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_ev_t ev;
    assign ev = '{buserr: ev_buserr[c], start: ev_start[c], done: ev_end[c],
                  stop: ev_stop[c], ras: ev_ras[c], eor: ev_eor[c]};
    dmas_chan_reg u_reg (
      .clk     (clk),
      .rst     (rst),
      .wr_hit  (wr_en && (widx == WIDX_W'(c))),
      .wdata   (wdata),
      .ev      (ev),
      .state_q (chan_word[c]),
      .src_o   (chan_src[c])
    );
  end

  dmas_irq_comb #(.NUM_CH(NUM_CH)) u_comb (
    .src      (chan_src),
    .v_stop   (irq_stop),
    .v_eor    (irq_eor),
    .v_ras    (irq_ras),
    .v_start  (irq_start),
    .v_end    (irq_end),
    .global_o (global_vec),
    .any_o    (irq)
  );

  if (NUM_CH < WORD_W) begin : g_gw_pad
    assign global_word = {{(WORD_W-NUM_CH){1'b0}}, global_vec};
  end else begin : g_gw_full
    assign global_word = global_vec[WORD_W-1:0];
  end

  always_comb begin
    rd_mux = '0;
    if (int'(widx) < NUM_CH) begin
      rd_mux = chan_word[CH_W'(widx)];
      rd_mux[F_REQ] = req_active[CH_W'(widx)];
    end else if (widx == WIDX_W'(GLOBAL_OFS / 4)) begin
      rd_mux = global_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R6
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(wr_en || (|ev_start) || (|ev_end) || (|ev_stop)
                         || (|ev_eor) || (|ev_ras))); // R10
  AST_BUSERR_SILENT: assert property (@(posedge clk) disable iff (rst)
    !wr_en && !(|ev_start) && !(|ev_end) && !(|ev_stop) && !(|ev_eor)
      && !(|ev_ras) |=> $stable(irq)); // R8
endmodule

// File: tb/dma_chan_status_tb_top.sv
module dma_chan_status_tb_top;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] req_active = '0, ev_start = '0, ev_end = '0, ev_stop = '0;
  logic [N-1:0] ev_eor = '0, ev_ras = '0, ev_buserr = '0;
  logic [N-1:0] irq_stop, irq_eor, irq_ras, irq_start, irq_end;
  logic         irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_chan_status dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .req_active(req_active),
    .ev_start(ev_start), .ev_end(ev_end), .ev_stop(ev_stop), .ev_eor(ev_eor),
    .ev_ras(ev_ras), .ev_buserr(ev_buserr), .irq_stop(irq_stop),
    .irq_eor(irq_eor), .irq_ras(irq_ras), .irq_start(irq_start),
    .irq_end(irq_end), .irq(irq)
  );

  // ---------------- reference model ----------------
  bit [31:0] m_st [N];
  bit [31:0] m_rd;

  function automatic bit [31:0] m_global();
    bit [31:0] g = 0;
    for (int c = 0; c < N; c++) begin
      if (m_st[c][3] && m_st[c][29]) g[c] = 1;
      if (m_st[c][9] && m_st[c][28]) g[c] = 1;
      if (m_st[c][4] && m_st[c][23]) g[c] = 1;
      if (m_st[c][1] || m_st[c][2])  g[c] = 1;
    end
    return g;
  endfunction

  task automatic model_edge();
    if (rst) begin
      for (int c = 0; c < N; c++) m_st[c] = 32'h8;
      m_rd = 0;
      return;
    end
    if (rd_en) begin
      if (addr[7:2] < N) begin
        m_rd = m_st[addr[7:2]];
        if (req_active[addr[7:2]]) m_rd = m_rd | 32'h100;
      end else if (addr[7:2] == 6'h3C) m_rd = m_global();
      else m_rd = 0;
    end
    for (int c = 0; c < N; c++) begin
      bit [31:0] s = m_st[c];
      if (wr_en && addr[7:2] == c) begin
        bit [31:0] keep = s & 32'h71F;
        for (int b = 0; b < 32; b++) begin
          if ((b <= 2 || b == 9) && wdata[b]) keep[b] = 0;
          if ((b >= 26 || b == 23) && wdata[b]) keep[b] = 1;
        end
        if (wdata[31]) keep[3] = 0;
        else if (!wdata[22]) keep[3] = 1;
        if (wdata[24]) keep[10] = 0;
        if (wdata[25]) keep[10] = 1;
        s = keep;
      end
      if (ev_buserr[c]) s[0] = 1;
      if (ev_start[c])  s[1] = 1;
      if (ev_end[c])    s[2] = 1;
      if (ev_stop[c])   s[3] = 1;
      if (ev_ras[c])    s[4] = 1;
      if (ev_eor[c])    s[9] = 1;
      m_st[c] = s;
    end
  endtask

  task automatic cmp(string tag, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    bit [31:0] es = 0, ee = 0, er = 0, ea = 0, en = 0;
    for (int c = 0; c < N; c++) begin
      es[c] = m_st[c][3] & m_st[c][29];
      ee[c] = m_st[c][9] & m_st[c][28];
      er[c] = m_st[c][4] & m_st[c][23];
      ea[c] = m_st[c][1];
      en[c] = m_st[c][2];
    end
    cmp("R8 stop vector", irq_stop, es);
    cmp("R8 eor vector", irq_eor, ee);
    cmp("R8 ras vector", irq_ras, er);
    cmp("R9 start vector", irq_start, ea);
    cmp("R9 end vector", irq_end, en);
    cmp("R10 irq line", {31'b0, irq}, {31'b0, m_global() != 0});
    cmp("R6 rdata model", rdata, m_rd);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    step();
    wr_en = 0; wdata = 0;
  endtask

  task automatic rd(bit [7:0] a, string tag, bit [31:0] exp);
    rd_en = 1; addr = a;
    step();
    rd_en = 0;
    cmp(tag, rdata, exp);
  endtask

  task automatic clr_ev();
    ev_start = 0; ev_end = 0; ev_stop = 0; ev_eor = 0; ev_ras = 0; ev_buserr = 0;
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(); step();
    rst = 0;
    // R1 reset state
    cmp("R1 rdata after reset", rdata, 0);
    cmp("R1 irq after reset", {31'b0, irq}, 0);
    rd(8'h00, "R1 ch0 word", 32'h8);
    rd(8'hF0, "R1 global word", 32'h0);
    // R3/R5 load control, run clears stop
    wr(8'h0C, 32'hB080_0000);
    rd(8'h0C, "R3 R5 ch3 control load", 32'hB080_0000);
    // R4 both commands, R3 commands read 0
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, "R4 R3 ch3 all ones", 32'hFC80_0400);
    wr(8'h0C, 32'h8100_0000);
    rd(8'h0C, "R4 ch3 compare cleared", 32'h8000_0000);
    // R7/R9 start and end events
    ev_start[5] = 1; ev_end[5] = 1; step(); clr_ev();
    rd(8'h14, "R7 ch5 flags", 32'hE);
    cmp("R9 irq from end/start", {31'b0, irq}, 1);
    rd(8'hF0, "R10 global ch5", 32'h20);
    // R2/R5 run keeps flags, mask-run clear end, idle clear start
    wr(8'h14, 32'h8000_0000);
    rd(8'h14, "R2 R5 run write", 32'h8000_0006);
    wr(8'h14, 32'h0040_0004);
    rd(8'h14, "R5 mask-run keeps stop, R2 end clear", 32'h2);
    wr(8'h14, 32'h0000_0002);
    rd(8'h14, "R5 idle sets stop, R2 start clear", 32'h8);
    cmp("R10 irq low", {31'b0, irq}, 0);
    // R8 stop gating
    ev_stop[7] = 1; step(); clr_ev();
    rd(8'hF0, "R8 stop ungated", 32'h0);
    wr(8'h1C, 32'h2040_0000);
    rd(8'hF0, "R8 stop enabled", 32'h80);
    // R8/R7 end-of-receive
    ev_eor[9] = 1; step(); clr_ev();
    rd(8'h24, "R7 ch9 eor flag", 32'h208);
    rd(8'hF0, "R8 eor not enabled", 32'h80);
    wr(8'h24, 32'h1040_0000);
    rd(8'hF0, "R8 eor enabled", 32'h280);
    ev_eor[9] = 1; wr(8'h24, 32'h1040_0200); clr_ev();
    rd(8'h24, "R7 event beats clear", 32'h1000_0208);
    // R8 request-after-stop
    ev_ras[11] = 1; step(); clr_ev();
    rd(8'h2C, "R7 ch11 ras flag", 32'h18);
    rd(8'hF0, "R8 ras not enabled", 32'h280);
    // R6 request pending and unmapped
    req_active[12] = 1;
    rd(8'h30, "R6 request pending", 32'h108);
    req_active[12] = 0;
    rd(8'h30, "R6 request gone", 32'h8);
    rd(8'hA0, "R6 unmapped", 32'h0);
    // R8 bus error silent
    ev_buserr[0] = 1; step(); clr_ev();
    rd(8'h00, "R7 bus error flag", 32'h9);
    rd(8'hF0, "R8 bus error no irq", 32'h280);
    // R7 stop event with run write
    ev_stop[13] = 1; wr(8'h34, 32'h8000_0000); clr_ev();
    rd(8'h34, "R7 stop beats run", 32'h8000_0008);
    // R10 all channels, top index
    ev_end = '1; step(); clr_ev();
    rd(8'hF0, "R10 global all", 32'hFFFF_FFFF);
    rd(8'h7C, "R9 ch31 end", 32'hC);
    wr(8'h7C, 32'h4);
    rd(8'hF0, "R10 global ch31 cleared", 32'h7FFF_FFFF);
    step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule